// File: doc/BRIEF.md
# ATA PIO Strobe Cycle Timer

This block times single programmed-I/O accesses on an ATA bus for a host controller. It keeps two 3-bit speed codes. The first covers accesses to the task-file and command registers. The second covers accesses to the data register. When a request arrives with a class flag that says which kind of register is addressed, the block looks up the minimum cycle time for the matching code. It converts that time into a whole number of system clocks, rounding up, using a clock-period parameter given in picoseconds.

The access then runs for exactly that many clocks. The read or write strobe is active (low) for the first half of the count, rounded up, and inactive for the rest. A single-clock done pulse follows the access. While an access is running, ready is low and any request is dropped, not stored.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset both speed codes are 000, ready is 1, both strobes are high and done is 0; an access made without programming a code therefore lasts 60 clocks at a 10 ns clock.
- R2: The access length in clocks is ceil(T / CLK_PERIOD_PS), where T is 600 ns for code 000, 383 ns for 001, 330 ns for 010, 180 ns for 011 and 120 ns for 100. At 10 ns this gives 60, 39, 33, 18 and 12 clocks.
- R3: Codes 101, 110 and 111 give the code-000 timing, which is 60 clocks at 10 ns.
- R4: A request with is_data_i = 0 is timed by the command code. A request with is_data_i = 1 is timed by the data code.
- R5: For an access of N clocks, the selected strobe is low for the first (N+1)/2 clocks and high for the remaining clocks. Reads (rd_i = 1) drive only dior_n_o. Writes drive only diow_n_o.
- R6: done_o is high for exactly one clock, in the clock that follows the last clock of the access. ready_o is high in that clock.
- R7: A request is accepted only on an edge where ready_o is 1. ready_o is then low for exactly N clocks. A request made while ready_o is 0 is dropped and causes no later access.
- R8: A code written while an access is running does not change that access. It takes effect from the next accepted request.
- R9: Writing one code field leaves the other field unchanged. A field keeps its value when its write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_mode_we_i | input | 1 | Loads cmd_mode_i into the command speed code |
| cmd_mode_i | input | 3 | New command speed code |
| dat_mode_we_i | input | 1 | Loads dat_mode_i into the data speed code |
| dat_mode_i | input | 3 | New data speed code |
| req_i | input | 1 | Access request, taken when ready_o is 1 |
| is_data_i | input | 1 | 1 = data register access, 0 = task-file or command register |
| rd_i | input | 1 | 1 = read, 0 = write |
| ready_o | output | 1 | High when idle and able to accept a request |
| dior_n_o | output | 1 | Active-low read strobe |
| diow_n_o | output | 1 | Active-low write strobe |
| done_o | output | 1 | One-clock pulse after each access |

## Verification
Two situations are hard to produce from the ports. One is a code change that lands in the middle of a running access. The other is a request that arrives while the block is busy. To cover the first, the stimulus rewrites the command code a few clocks after an access is accepted. The scoreboard then expects the old length for that access and the new length for the next one. To cover the second, a one-clock request pulse is sent while ready is low. After that access ends, the bench watches the idle bus over several clocks to confirm that no second strobe appears and no second done arrives. The monitor also flags any done that the queue did not expect.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   localparam int unsigned MODE_W   = 3;
   localparam int unsigned NUM_CODE = 1 << MODE_W;
   localparam int unsigned NUM_FLD  = 2;   // 0: command class, 1: data register

   typedef logic [MODE_W-1:0] pio_code_t;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_ASSERT  = 2'd1,
      SEQ_RECOVER = 2'd2
   } seq_state_t;

   // Minimum cycle time in picoseconds; unused codes map to the slowest one.
   function automatic int unsigned pio_min_ps(input int unsigned code);
      case (code)
         1:       return 383000;
         2:       return 330000;
         3:       return 180000;
         4:       return 120000;
         default: return 600000;
      endcase
   endfunction

   function automatic int unsigned div_up(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/ata_pio_mode_reg.sv
module ata_pio_mode_reg #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W == 0) begin : g_bad_w
      $error("ata_pio_mode_reg: W must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> (q_o == $past(q_o))); // R9

endmodule

// File: rtl/ata_pio_cycle_lut.sv
module ata_pio_cycle_lut
   import ata_pio_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter int unsigned CNT_W         = 16
) (
   input  pio_code_t          code_i,
   output logic [CNT_W-1:0]   total_o,
   output logic [CNT_W-1:0]   active_o
);

   localparam int unsigned MAX_CYC = div_up(600000, CLK_PERIOD_PS);
   localparam int unsigned MIN_CYC = div_up(120000, CLK_PERIOD_PS);

   if (CLK_PERIOD_PS == 0) begin : g_bad_period
      $error("ata_pio_cycle_lut: CLK_PERIOD_PS must be non-zero");
   end
   if (MIN_CYC < 2) begin : g_too_slow
      $error("ata_pio_cycle_lut: clock too slow for a two-phase fastest cycle");
   end
   if (MAX_CYC >= (64'd1 << CNT_W)) begin : g_narrow
      $error("ata_pio_cycle_lut: CNT_W too narrow for slowest cycle count");
   end

   logic [CNT_W-1:0] tot_tab [NUM_CODE];
   logic [CNT_W-1:0] act_tab [NUM_CODE];

   for (genvar g = 0; g < NUM_CODE; g++) begin : g_code
      localparam int unsigned TOT = div_up(pio_min_ps(g), CLK_PERIOD_PS);
      localparam int unsigned ACT = (TOT + 1) / 2;
      assign tot_tab[g] = CNT_W'(TOT);
      assign act_tab[g] = CNT_W'(ACT);
   end

   assign total_o  = tot_tab[code_i];
   assign active_o = act_tab[code_i];

   always_comb begin
      AST_PHASES_NONEMPTY: assert (active_o != '0 && active_o < total_o); // R5
   end

endmodule

// File: rtl/ata_pio_strobe_seq.sv
module ata_pio_strobe_seq
   import ata_pio_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             rd_i,
   input  logic [CNT_W-1:0] total_i,
   input  logic [CNT_W-1:0] active_i,
   output logic             ready_o,
   output logic             dior_n_o,
   output logic             diow_n_o,
   output logic             done_o
);

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rec_q;
   logic             rd_q;
   logic             accept;
   logic             last_clk;

   assign accept   = req_i && (state_q == SEQ_IDLE);
   assign last_clk = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         rec_q   <= '0;
         rd_q    <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  state_q <= SEQ_ASSERT;
                  cnt_q   <= active_i;
                  rec_q   <= total_i - active_i;
                  rd_q    <= rd_i;
               end
            end
            SEQ_ASSERT: begin
               if (last_clk) begin
                  state_q <= SEQ_RECOVER;
                  cnt_q   <= rec_q;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SEQ_RECOVER: begin
               if (last_clk) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
                  done_o  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               state_q <= SEQ_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign ready_o  = (state_q == SEQ_IDLE);
   assign dior_n_o = !((state_q == SEQ_ASSERT) &&  rd_q);
   assign diow_n_o = !((state_q == SEQ_ASSERT) && !rd_q);

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && ready_o) |=> !ready_o); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ready_o && $past(!ready_o))); // R6

   AST_NO_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RECOVER) |=> (dior_n_o && diow_n_o)); // R5

   AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && $past(!ready_o)) |-> $stable(rd_q)); // R5

   AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SEQ_IDLE) |-> (cnt_q != '0)); // R7

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
   import ata_pio_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter int unsigned CNT_W         = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_mode_we_i,
   input  logic [2:0] cmd_mode_i,
   input  logic       dat_mode_we_i,
   input  logic [2:0] dat_mode_i,
   input  logic       req_i,
   input  logic       is_data_i,
   input  logic       rd_i,
   output logic       ready_o,
   output logic       dior_n_o,
   output logic       diow_n_o,
   output logic       done_o
);

   logic      fld_we [NUM_FLD];
   pio_code_t fld_d  [NUM_FLD];
   pio_code_t fld_q  [NUM_FLD];

   assign fld_we[0] = cmd_mode_we_i;
   assign fld_d[0]  = cmd_mode_i;
   assign fld_we[1] = dat_mode_we_i;
   assign fld_d[1]  = dat_mode_i;

   for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      ata_pio_mode_reg #(.W(MODE_W)) u_fld (
         .clk   (clk),
         .rst_n (rst_n),
         .we_i  (fld_we[f]),
         .d_i   (fld_d[f]),
         .q_o   (fld_q[f])
      );
   end

   pio_code_t        sel_code;
   logic [CNT_W-1:0] total;
   logic [CNT_W-1:0] active;

   assign sel_code = is_data_i ? fld_q[1] : fld_q[0];

   ata_pio_cycle_lut #(
      .CLK_PERIOD_PS (CLK_PERIOD_PS),
      .CNT_W         (CNT_W)
   ) u_lut (
      .code_i   (sel_code),
      .total_o  (total),
      .active_o (active)
   );

   ata_pio_strobe_seq #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .rd_i     (rd_i),
      .total_i  (total),
      .active_i (active),
      .ready_o  (ready_o),
      .dior_n_o (dior_n_o),
      .diow_n_o (diow_n_o),
      .done_o   (done_o)
   );

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (dior_n_o || diow_n_o)); // R5

   AST_STROBE_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!dior_n_o || !diow_n_o) |-> !ready_o); // R7

endmodule

// File: tb/sim_ata_pio_timer.sv
module sim_ata_pio_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_mode_we = 1'b0;
   logic [2:0] cmd_mode = 3'd0;
   logic       dat_mode_we = 1'b0;
   logic [2:0] dat_mode = 3'd0;
   logic       req = 1'b0;
   logic       is_data = 1'b0;
   logic       rd = 1'b0;
   logic       ready, dior_n, diow_n, done;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   typedef struct {
      bit    rd;
      int    low;
      int    tot;
      string tag;
   } exp_t;

   exp_t exp_q[$];

   always #5 clk = ~clk;

   ata_pio_timer u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_mode_we_i (cmd_mode_we),
      .cmd_mode_i    (cmd_mode),
      .dat_mode_we_i (dat_mode_we),
      .dat_mode_i    (dat_mode),
      .req_i         (req),
      .is_data_i     (is_data),
      .rd_i          (rd),
      .ready_o       (ready),
      .dior_n_o      (dior_n),
      .diow_n_o      (diow_n),
      .done_o        (done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Expected length at a 10 ns clock, from the minimum times in R2 and R3.
   function automatic int exp_len(input int code);
      int ns;
      case (code)
         1: ns = 383;
         2: ns = 330;
         3: ns = 180;
         4: ns = 120;
         default: ns = 600;
      endcase
      return (ns + 9) / 10;
   endfunction

   // Monitor: counts busy and strobe clocks, scores each access on done.
   int  m_tot = 0, m_rd = 0, m_wr = 0;
   bit  m_prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!ready)  m_tot++;
         if (!dior_n) m_rd++;
         if (!diow_n) m_wr++;
         if (done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(m_tot == e.tot, {e.tag, " length"}, m_tot, e.tot);
               if (e.rd) begin
                  check(m_rd == e.low, {e.tag, " R5 read strobe low"}, m_rd, e.low);
                  check(m_wr == 0, {e.tag, " R5 write strobe idle"}, m_wr, 0);
               end else begin
                  check(m_wr == e.low, {e.tag, " R5 write strobe low"}, m_wr, e.low);
                  check(m_rd == 0, {e.tag, " R5 read strobe idle"}, m_rd, 0);
               end
               check(ready == 1'b1, {e.tag, " R6 ready with done"}, ready, 1);
            end
            m_tot = 0; m_rd = 0; m_wr = 0;
         end
         if (m_prev_done && done) check(1'b0, "R6 done wider than one clock", 2, 1);
         m_prev_done = done;
      end
   end

   task automatic set_cmd(input int code);
      @(negedge clk); cmd_mode_we = 1'b1; cmd_mode = 3'(code);
      @(negedge clk); cmd_mode_we = 1'b0;
   endtask

   task automatic set_dat(input int code);
      @(negedge clk); dat_mode_we = 1'b1; dat_mode = 3'(code);
      @(negedge clk); dat_mode_we = 1'b0;
   endtask

   // Driver: pushes the expected item and issues one request.
   task automatic access(input bit r, input bit dat, input int tot, input string tag);
      exp_t e;
      e.rd = r; e.low = (tot + 1) / 2; e.tot = tot; e.tag = tag;
      @(negedge clk);
      while (!ready) @(negedge clk);
      exp_q.push_back(e);
      req = 1'b1; rd = r; is_data = dat;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(ready == 1'b1 && dior_n && diow_n && !done, "R1 idle outputs in reset", ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b1 && dior_n && diow_n && !done, "R1 idle outputs after reset", ready, 1);

      // R1: default codes are 000 for both classes.
      access(1'b1, 1'b0, exp_len(0), "R1 default cmd");
      drain();
      access(1'b0, 1'b1, exp_len(0), "R1 default data");
      drain();

      // R2 / R3: every command code, alternating direction.
      for (int c = 0; c < 8; c++) begin
         set_cmd(c);
         access(c[0], 1'b0, exp_len(c), (c > 4) ? "R3 reserved code" : "R2 code");
         drain();
      end

      // R4 / R9: separate fields.
      set_cmd(1);
      set_dat(4);
      access(1'b0, 1'b1, 12, "R4 data field");
      drain();
      access(1'b1, 1'b0, 39, "R4 cmd field");
      drain();
      set_dat(3);
      access(1'b1, 1'b0, 39, "R9 cmd kept after data write");
      drain();
      access(1'b1, 1'b1, 18, "R9 data field updated");
      drain();

      // R8: code rewritten mid-access.
      access(1'b1, 1'b0, 39, "R8 running access keeps old code");
      repeat (3) @(negedge clk);
      cmd_mode_we = 1'b1; cmd_mode = 3'd4;
      @(negedge clk);
      cmd_mode_we = 1'b0;
      drain();
      access(1'b0, 1'b0, 12, "R8 next access uses new code");
      drain();

      // R7: request pulse while busy is dropped.
      access(1'b0, 1'b1, 18, "R7 busy access");
      repeat (4) @(negedge clk);
      check(ready == 1'b0, "R7 ready low while busy", ready, 0);
      req = 1'b1; rd = 1'b1;
      @(negedge clk);
      req = 1'b0;
      drain();
      begin
         int bad = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!ready || !dior_n || !diow_n || done) bad++;
         end
         check(bad == 0, "R7 dropped request caused no access", bad, 0);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule